// File: doc/BRIEF.md
# Quad-precision floating-point add/subtract unit

This block adds or subtracts two 128-bit binary128 floating-point operands. Each operand has a sign bit at bit 127, a 15-bit biased exponent in bits 126:112 (bias 16383) and a 112-bit fraction in bits 111:0. The unit recognises zeros of either sign, subnormals (exponent field 0 with a nonzero fraction), infinities and NaNs (exponent field 0x7FFF with a zero or a nonzero fraction). For finite operands it aligns the smaller operand while keeping guard, round and sticky information, adds or subtracts the significands, normalises the result and rounds it in one of four modes.

A request is a one-cycle `en` strobe with the operation code, the rounding mode and both operands. The unit latches them and works for a fixed number of cycles. It then raises `done` for one cycle, with the rounded result and four exception flags valid. Result and flags hold until the next `done`. While a request is in flight, further strobes are dropped.

Top module: `qp_addsub`

## Requirements
- R1: With `op`=000 the unit returns the correctly rounded sum a+b. With `op`=001 it returns a-b. Both use the binary128 layout: sign bit 127, exponent bits 126:112 with bias 16383, fraction bits 111:0, and a hidden 1 for exponent fields other than 0 and 0x7FFF.
- R2: A strobe with any `op` other than 000 or 001 starts nothing. No `done` follows it, and `result` and `flags` keep their values.
- R3: `done` is a one-cycle pulse. It is asserted exactly LAT clock edges after the edge that accepted `en` (default LAT=26). `result` and `flags` hold until the next `done`.
- R4: A strobe that arrives while a request is in flight is ignored. Only the first request produces a `done`, and that `done` carries the first request's result.
- R5: A negative true result has sign bit 1. An exact zero from opposite-signed operands is +0, except in mode 11, where it is -0. The sum of two zeros of the same sign keeps that sign.
- R6: `rmode` encodings are 00 nearest-even (ties go to an even last bit), 01 toward zero, 10 toward +infinity and 11 toward -infinity. Bits shifted out during alignment count toward the rounding decision.
- R7: Subnormal operands have a hidden bit of 0 and an effective exponent of 1. A sum that carries into the hidden position becomes the smallest normal number (exponent field 1).
- R8: If either input is a NaN, the result is the canonical quiet NaN 0x7FFF8000...0 (sign 0, fraction MSB 1, other fraction bits 0), and all flags are clear.
- R9: Adding infinities of opposite effective sign gives the canonical quiet NaN with the invalid flag set. Any other case with an infinite input returns that infinity, with no flags.
- R10: If the rounded exponent reaches 0x7FFF, overflow and inexact are set. The result is infinity in mode 00, and in modes 10 and 11 when rounding points toward the result's sign. Otherwise it is the largest finite value, exponent 0x7FFE with an all-ones fraction.
- R11: `flags` bit order is [3] invalid, [2] overflow, [1] underflow (subnormal or zero result that is inexact), [0] inexact (nonzero bits discarded by rounding).
- R12: After reset, `done`, `result` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Request strobe |
| op | input | 3 | Operation: 000 add, 001 subtract |
| rmode | input | 2 | Rounding mode |
| a | input | 128 | First operand |
| b | input | 128 | Second operand |
| result | output | 128 | Rounded result, valid with done |
| done | output | 1 | One-cycle completion pulse |
| flags | output | 4 | {invalid, overflow, underflow, inexact} |

## Verification
Several properties are checked on every cycle:
- `done` never lasts more than one cycle and only ends an in-flight request.
- The latched operands stay still while a request is in flight.
- Any flagged invalid result is the canonical quiet NaN.
- Any returned NaN is quiet.
- Overflow always comes with inexact.

The numeric behaviour can only be shown by the bench's scenarios. These cover:
- tie-breaking to even and the directed modes;
- the sign of exact zeros;
- massive cancellation down to a tiny result;
- subnormal sums that cross into the normal range;
- overflow to infinity versus the largest finite value;
- the exact latency and the ignored strobes.

// File: rtl/qp_addsub.sv
module qp_addsub #(
  parameter int LAT = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [2:0]   op,
  input  logic [1:0]   rmode,
  input  logic [127:0] a,
  input  logic [127:0] b,
  output logic [127:0] result,
  output logic         done,
  output logic [3:0]   flags
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [127:0] QNAN = {1'b0, 15'h7fff, 1'b1, 111'd0};

  logic          busy, sub_q;
  logic [CW-1:0] cnt;
  logic [127:0]  ra, rb, nxt_res;
  logic [1:0]    rm_q;
  logic [3:0]    nxt_fl;

  wire start = en && !busy && (op[2:1] == 2'b00);

  wire         sa = ra[127];
  wire         sb = rb[127] ^ sub_q;
  wire [14:0]  ea = ra[126:112];
  wire [14:0]  eb = rb[126:112];
  wire         a_nan = (&ea) && (|ra[111:0]);
  wire         b_nan = (&eb) && (|rb[111:0]);
  wire         a_inf = (&ea) && !(|ra[111:0]);
  wire         b_inf = (&eb) && !(|rb[111:0]);
  wire         eff_sub = sa ^ sb;
  wire         a_big = ra[126:0] >= rb[126:0];
  wire         sx = a_big ? sa : sb;
  wire [126:0] bigm = a_big ? ra[126:0] : rb[126:0];
  wire [126:0] smlm = a_big ? rb[126:0] : ra[126:0];
  wire [15:0]  ex = (bigm[126:112] == 15'd0) ? 16'd1 : {1'b0, bigm[126:112]};
  wire [15:0]  ey = (smlm[126:112] == 15'd0) ? 16'd1 : {1'b0, smlm[126:112]};
  wire [112:0] mx = {|bigm[126:112], bigm[111:0]};
  wire [112:0] my = {|smlm[126:112], smlm[111:0]};
  wire [15:0]  d  = ex - ey;
  wire [6:0]   dc = (d > 16'd117) ? 7'd117 : d[6:0];
  wire [231:0] wide = {my, 3'b000, 116'd0} >> dc;
  wire [115:0] al = {wide[231:117], wide[116] | (|wide[115:0])};
  wire [116:0] xx = {1'b0, mx, 3'b000};
  wire [116:0] yy = {1'b0, al};
  wire [116:0] rr = eff_sub ? (xx - yy) : (xx + yy);

  logic [6:0]   lz;
  logic [15:0]  sh;
  logic [115:0] n;
  logic [16:0]  e;
  always_comb begin
    lz = 7'd116;
    for (int i = 0; i < 116; i++)
      if (rr[i]) lz = 7'(115 - i);
    sh = ({9'd0, lz} > (ex - 16'd1)) ? (ex - 16'd1) : {9'd0, lz};
    if (rr[116]) begin
      n = {rr[116:2], rr[1] | rr[0]};
      e = {1'b0, ex} + 17'd1;
    end else begin
      n = rr[115:0] << sh;
      e = {1'b0, ex} - {1'b0, sh};
    end
  end

  wire sgn = (rr == 117'd0) ? (eff_sub ? (rm_q == 2'b11) : sx) : sx;
  wire lsb = n[3];
  wire g   = n[2];
  wire st  = |n[1:0];
  wire inx = g | st;
  logic inc;
  always_comb begin
    case (rm_q)
      2'b00:   inc = g & (st | lsb);
      2'b01:   inc = 1'b0;
      2'b10:   inc = !sgn & inx;
      default: inc = sgn & inx;
    endcase
  end

  wire [113:0] rs   = {1'b0, n[115:3]} + {113'd0, inc};
  wire [16:0]  e2   = rs[113] ? (e + 17'd1) : e;
  wire         hid  = rs[113] | rs[112];
  wire [111:0] frac = rs[113] ? 112'd0 : rs[111:0];
  wire [14:0]  efld = hid ? e2[14:0] : 15'd0;
  wire         ovf  = hid && (e2 >= 17'h7fff);
  wire         to_inf = (rm_q == 2'b00) || (rm_q == 2'b10 && !sgn) || (rm_q == 2'b11 && sgn);

  always_comb begin
    if (a_nan || b_nan) begin
      nxt_res = QNAN;                          nxt_fl = 4'b0000;
    end else if (a_inf && b_inf && eff_sub) begin
      nxt_res = QNAN;                          nxt_fl = 4'b1000;
    end else if (a_inf) begin
      nxt_res = {sa, 15'h7fff, 112'd0};        nxt_fl = 4'b0000;
    end else if (b_inf) begin
      nxt_res = {sb, 15'h7fff, 112'd0};        nxt_fl = 4'b0000;
    end else if (ovf) begin
      nxt_res = to_inf ? {sgn, 15'h7fff, 112'd0} : {sgn, 15'h7ffe, {112{1'b1}}};
      nxt_fl  = 4'b0101;
    end else begin
      nxt_res = {sgn, efld, frac};             nxt_fl = {2'b00, !hid & inx, inx};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; sub_q <= 1'b0; rm_q <= 2'b00;
      ra <= '0; rb <= '0; result <= '0; flags <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1; cnt <= '0; ra <= a; rb <= b; sub_q <= op[0]; rm_q <= rmode;
      end else if (busy) begin
        if (cnt == CW'(LAT - 1)) begin
          busy <= 1'b0; done <= 1'b1; result <= nxt_res; flags <= nxt_fl;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                      // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));                                     // R3
  AST_OPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ra) && $stable(rb) && $stable(rm_q))); // R4
  AST_INVALID_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flags[3]) |-> (result == QNAN));                             // R9
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (&result[126:112]) && (|result[111:0])) |-> result[111]);     // R8
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flags[2]) |-> flags[0]);                                     // R10
endmodule

// File: tb/qp_addsub_tb_top.sv
module qp_addsub_tb_top;
  localparam int LAT = 26;
  localparam logic [127:0] ZERO  = 128'd0;
  localparam logic [127:0] NZERO = {16'h8000, 112'd0};
  localparam logic [127:0] ONE   = {16'h3fff, 112'd0};
  localparam logic [127:0] ONEU  = {16'h3fff, 112'd1};
  localparam logic [127:0] ONE2U = {16'h3fff, 112'd2};
  localparam logic [127:0] TWO   = {16'h4000, 112'd0};
  localparam logic [127:0] THREE = {16'h4000, 4'h8, 108'd0};
  localparam logic [127:0] NONE  = {16'hbfff, 112'd0};
  localparam logic [127:0] TINY  = {16'h3f8e, 112'd0};
  localparam logic [127:0] OMH   = {16'h3ffe, {112{1'b1}}};
  localparam logic [127:0] PINF  = {16'h7fff, 112'd0};
  localparam logic [127:0] NINF  = {16'hffff, 112'd0};
  localparam logic [127:0] QNAN  = {16'h7fff, 4'h8, 108'd0};
  localparam logic [127:0] SNAN  = {16'h7fff, 112'd1};
  localparam logic [127:0] MAXF  = {16'h7ffe, {112{1'b1}}};
  localparam logic [127:0] NMAXF = {16'hfffe, {112{1'b1}}};
  localparam logic [127:0] DMIN  = {16'h0000, 112'd1};
  localparam logic [127:0] DMIN2 = {16'h0000, 112'd2};
  localparam logic [127:0] DMAX  = {16'h0000, {112{1'b1}}};
  localparam logic [127:0] NMIN  = {16'h0001, 112'd0};

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [2:0] op = 3'd0;
  logic [1:0] rmode = 2'd0;
  logic [127:0] a = '0, b = '0;
  logic [127:0] result;
  logic done;
  logic [3:0] flags;
  int total = 0, bad = 0, cyc = 0, ndone = 0;

  logic [127:0] q_res[$];
  logic [3:0]   q_fl[$];
  int           q_st[$];
  string        q_tag[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qp_addsub #(.LAT(LAT)) dut_i (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .rmode(rmode),
    .a(a), .b(b), .result(result), .done(done), .flags(flags));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      ndone++;
      if (q_res.size() == 0) begin
        chk(1'b0, "R2/R4 unexpected done", result, '0);
      end else begin
        automatic logic [127:0] er = q_res.pop_front();
        automatic logic [3:0]   ef = q_fl.pop_front();
        automatic int           es = q_st.pop_front();
        automatic string        tg = q_tag.pop_front();
        chk(result == er, {tg, " result"}, result, er);
        chk(flags == ef, {tg, " flags"}, {124'd0, flags}, {124'd0, ef});
        chk(cyc - es == LAT + 1, "R3 latency", 128'(cyc - es), 128'(LAT + 1));
      end
    end
  end

  task automatic drive(input logic [2:0] o, input logic [1:0] rm, input logic [127:0] x, input logic [127:0] y);
    @(negedge clk);
    op = o; rmode = rm; a = x; b = y; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic run(input logic [2:0] o, input logic [1:0] rm, input logic [127:0] x,
                     input logic [127:0] y, input logic [127:0] er, input logic [3:0] ef, input string tag);
    @(negedge clk);
    q_res.push_back(er); q_fl.push_back(ef); q_st.push_back(cyc); q_tag.push_back(tag);
    op = o; rmode = rm; a = x; b = y; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    while (q_res.size() != 0) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", '0, '0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && result == '0 && flags == 4'd0, "R12 reset state", result, '0);
    rst_n = 1'b1;
    // R1 basic add and subtract
    run(3'b000, 2'b00, ONE, TWO, THREE, 4'b0000, "R1 1+2");
    // R5 negative difference
    run(3'b001, 2'b00, ONE, TWO, NONE, 4'b0000, "R5 1-2");
    // R5 zero signs
    run(3'b001, 2'b00, ONE, ONE, ZERO, 4'b0000, "R5 1-1 rne");
    run(3'b001, 2'b11, ONE, ONE, NZERO, 4'b0000, "R5 1-1 rdn");
    run(3'b000, 2'b00, NZERO, NZERO, NZERO, 4'b0000, "R5 -0+-0");
    // R6 rounding with a half-ulp addend
    run(3'b000, 2'b00, ONE, TINY, ONE, 4'b0001, "R6 tie even down");
    run(3'b000, 2'b00, ONEU, TINY, ONE2U, 4'b0001, "R6 tie even up");
    run(3'b000, 2'b10, ONE, TINY, ONEU, 4'b0001, "R6 toward +inf");
    run(3'b000, 2'b01, ONEU, TINY, ONEU, 4'b0001, "R6 toward zero");
    run(3'b001, 2'b11, NONE, TINY, {16'hbfff, 112'd1}, 4'b0001, "R6 toward -inf");
    // R1 massive cancellation, exact
    run(3'b001, 2'b00, ONE, OMH, TINY, 4'b0000, "R1 cancellation");
    // R7 subnormals
    run(3'b000, 2'b00, DMIN, DMIN, DMIN2, 4'b0000, "R7 denorm sum");
    run(3'b000, 2'b00, DMAX, DMIN, NMIN, 4'b0000, "R7 denorm to normal");
    // R8 NaN propagation
    run(3'b000, 2'b00, SNAN, ONE, QNAN, 4'b0000, "R8 nan in a");
    run(3'b001, 2'b00, ONE, SNAN, QNAN, 4'b0000, "R8 nan in b");
    // R9 infinities
    run(3'b001, 2'b00, PINF, PINF, QNAN, 4'b1000, "R9 inf-inf");
    run(3'b000, 2'b00, NINF, PINF, QNAN, 4'b1000, "R9 -inf+inf");
    run(3'b000, 2'b00, PINF, ONE, PINF, 4'b0000, "R9 inf+1");
    run(3'b001, 2'b00, ONE, PINF, NINF, 4'b0000, "R9 1-inf");
    // R10 R11 overflow
    run(3'b000, 2'b00, MAXF, MAXF, PINF, 4'b0101, "R10 ovf rne");
    run(3'b000, 2'b01, MAXF, MAXF, MAXF, 4'b0101, "R10 ovf rtz");
    run(3'b000, 2'b11, MAXF, MAXF, MAXF, 4'b0101, "R10 ovf rdn pos");
    run(3'b000, 2'b11, NMAXF, NMAXF, NINF, 4'b0101, "R10 ovf rdn neg");
    run(3'b000, 2'b10, NMAXF, NMAXF, NMAXF, 4'b0101, "R11 ovf rup neg");
    // R2 unsupported code starts nothing
    begin
      automatic int n0 = ndone;
      drive(3'b010, 2'b00, ONE, ONE);
      repeat (LAT + 5) @(negedge clk);
      chk(ndone == n0, "R2 no done for op 010", 128'(ndone), 128'(n0));
      chk(result == NMAXF && flags == 4'b0101, "R2 outputs held", result, NMAXF);
      drive(3'b111, 2'b00, ONE, ONE);
      repeat (LAT + 5) @(negedge clk);
      chk(ndone == n0, "R2 no done for op 111", 128'(ndone), 128'(n0));
    end
    // R4 strobe while busy is dropped
    begin
      automatic int n0 = ndone;
      @(negedge clk);
      q_res.push_back(THREE); q_fl.push_back(4'b0000); q_st.push_back(cyc); q_tag.push_back("R4 first wins");
      op = 3'b000; rmode = 2'b00; a = ONE; b = TWO; en = 1'b1;
      @(negedge clk); en = 1'b0;
      repeat (3) @(negedge clk);
      drive(3'b001, 2'b00, ONE, TWO);
      repeat (2 * LAT + 5) @(negedge clk);
      chk(ndone == n0 + 1, "R4 single done", 128'(ndone), 128'(n0 + 1));
      chk(result == THREE, "R3 result held", result, THREE);
    end
    finish_up();
  end
endmodule